// File: doc/BRIEF.md
# Cipher Job Length Sequencer

This block holds the byte counts of one cipher job and decides when that job begins and ends. A host programs the payload length as two register writes (a 32-bit low word and a 29-bit high word, 61 bits in total) and the authentication-data length as one 32-bit write. A mode input picks between a basic single-pass mode and a combined authenticate-and-encrypt mode. The mode decides which register write launches the job. Once a job runs, every 16-byte block the host hands in is accepted and charged against the remaining counts. A stub datapath stands in for the cipher core. It moves each accepted block from a one-entry input buffer to a one-entry output buffer, where the host collects it.

The control is a three-state machine. **ST_IDLE** means the context registers are open for writing. **ST_RUN** means a job is in progress. **ST_SAVE** means a finished job waits for its saved context to be collected. The transitions are:

- **launch**: ST_IDLE to ST_RUN, on a valid start write.
- **finish_plain**: ST_RUN to ST_IDLE, when the counts and buffers are empty and no context save was requested.
- **finish_save**: ST_RUN to ST_SAVE, on the same condition when a save was requested.
- **collect**: ST_SAVE to ST_IDLE, when the host reads the saved context.

All other cycles hold the current state.

Top module: `job_len_seq`

## Requirements
- R1: After reset the state is ST_IDLE. `ctx_ready` is 1. `in_ready`, `out_ready`, `save_ready`, `job_start` and `job_done` are 0. Both remaining counts are 0.
- R2: With `combined_mode`=0, a write to select 1 (payload high word, bits [28:0]) launches the job. In the following cycle `job_start` is 1 for one cycle, `pay_remain` is {high word, stored low word} and `auth_remain` is 0. A write to select 2 does not launch in this mode.
- R3: With `combined_mode`=1, a write to select 2 (authentication length) launches the job. It loads `auth_remain` from that write and `pay_remain` from the stored words. Writes to selects 0 and 1 only store.
- R4: In combined mode, a launch write that would leave both lengths at zero is ignored: no `job_start`, and the block stays in ST_IDLE.
- R5: Each accepted block takes min(16, remaining) off `auth_remain` while it is nonzero, and otherwise off `pay_remain`. A final partial block clamps the count at 0.
- R6: `in_ready` is 1 only in ST_RUN, with the input buffer empty, and with a nonzero remaining count or an endless job. `blk_accept` = `blk_wr` & `in_ready`. A `blk_wr` while not ready changes nothing.
- R7: An accepted block fills the input buffer. It moves to the output buffer at the next edge if that buffer is empty, which raises `out_ready`. `out_read` empties the output buffer.
- R8: When both counts are 0 and both buffers are empty in ST_RUN, `job_done` pulses for one cycle and the machine leaves ST_RUN. Without a save request, `ctx_ready` returns to 1 in that same cycle.
- R9: A basic-mode launch with a zero payload length starts an endless job. It accepts blocks without limit, keeps `pay_remain` at 0 and never raises `job_done`.
- R10: `save_ctx` is sampled at launch. If it was set, the finishing job enters ST_SAVE, where `save_ready`=1 and `ctx_ready`=0, and `ctx_read` returns the machine to ST_IDLE. `ctx_ready` and `save_ready` are never 1 together.
- R11: `rd_data` is all zeros for `rd_sel` 0, 1 and 2. For `rd_sel` 3 it is {`save_ready`, `ctx_ready`, `out_ready`, `in_ready`} in bits [3:0], with zeros above.
- R12: Length-register writes outside ST_IDLE are ignored. They neither change the counts nor launch a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 payload low, 1 payload high, 2 auth length |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select |
| rd_data | output | 32 | Read data (zeros for lengths, status for select 3) |
| combined_mode | input | 1 | 1 = combined mode, 0 = basic mode |
| save_ctx | input | 1 | Request a saved-context phase at job end |
| ctx_read | input | 1 | Host collects the saved context |
| blk_wr | input | 1 | Host offers a 16-byte block |
| blk_accept | output | 1 | Block taken this cycle |
| out_read | input | 1 | Host reads the output block |
| job_start | output | 1 | One-cycle launch pulse |
| job_done | output | 1 | One-cycle finish pulse |
| pay_remain | output | 61 | Remaining payload bytes |
| auth_remain | output | 32 | Remaining authentication bytes |
| in_ready | output | 1 | Input buffer may be written |
| out_ready | output | 1 | Output block waiting |
| ctx_ready | output | 1 | Context registers writable |
| save_ready | output | 1 | Saved context waiting |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 29-bit high word and 16-byte blocks. With these values the full 61-bit launch value is checked through a directed load that uses the top bits of the high word. The random jobs use lengths below 130 bytes, so final partial blocks, exact multiples of 16 and the auth-then-payload hand-over all occur many times within a short run.

// File: rtl/job_len_pkg.sv
package job_len_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAVE = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEL_PAY_LO = 2'd0;
    localparam logic [1:0] SEL_PAY_HI = 2'd1;
    localparam logic [1:0] SEL_AUTH   = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;
endpackage

// File: rtl/job_len_regs.sv
module job_len_regs
    import job_len_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 29,
    localparam int PAY_W = DATA_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctx_open,
    input  logic              combined_mode,
    output logic              start_go,
    output logic [PAY_W-1:0]  start_pay,
    output logic [DATA_W-1:0] start_auth,
    output logic              start_comb
);
    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic [DATA_W-1:0] auth_q;
    logic              wr_ok;
    logic [PAY_W-1:0]  pay_now;
    logic [DATA_W-1:0] auth_now;

    generate
        if (HI_W < DATA_W) begin : g_hi_trim
            logic unused_hi_bits;
            assign unused_hi_bits = ^wr_data[DATA_W-1:HI_W];
        end
    endgenerate

    assign wr_ok = wr_en && ctx_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            auth_q <= '0;
        end else if (wr_ok) begin
            if (wr_sel == SEL_PAY_LO) lo_q   <= wr_data;
            if (wr_sel == SEL_PAY_HI) hi_q   <= wr_data[HI_W-1:0];
            if (wr_sel == SEL_AUTH)   auth_q <= wr_data;
        end
    end

    always_comb begin
        pay_now  = (wr_sel == SEL_PAY_HI) ? {wr_data[HI_W-1:0], lo_q} : {hi_q, lo_q};
        auth_now = (wr_sel == SEL_AUTH) ? wr_data : auth_q;
        start_comb = combined_mode;
        if (combined_mode) begin
            start_go   = wr_ok && (wr_sel == SEL_AUTH) && ((pay_now != '0) || (auth_now != '0));
            start_auth = auth_now;
        end else begin
            start_go   = wr_ok && (wr_sel == SEL_PAY_HI);
            start_auth = '0;
        end
        start_pay = pay_now;
    end
endmodule

// File: rtl/job_len_counters.sv
module job_len_counters #(
    parameter int PAY_W     = 61,
    parameter int AUTH_W    = 32,
    parameter int BLK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAY_W-1:0]  load_pay,
    input  logic [AUTH_W-1:0] load_auth,
    input  logic              dec,
    output logic [PAY_W-1:0]  pay_rem,
    output logic [AUTH_W-1:0] auth_rem,
    output logic              cnt_empty
);
    localparam logic [PAY_W-1:0]  BLK_P = PAY_W'(BLK_BYTES);
    localparam logic [AUTH_W-1:0] BLK_A = AUTH_W'(BLK_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_rem  <= '0;
            auth_rem <= '0;
        end else if (load) begin
            pay_rem  <= load_pay;
            auth_rem <= load_auth;
        end else if (dec) begin
            if (auth_rem != '0)
                auth_rem <= (auth_rem < BLK_A) ? '0 : auth_rem - BLK_A;
            else if (pay_rem != '0)
                pay_rem <= (pay_rem < BLK_P) ? '0 : pay_rem - BLK_P;
        end
    end

    assign cnt_empty = (pay_rem == '0) && (auth_rem == '0);

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !load |=> (pay_rem <= $past(pay_rem)) && (auth_rem <= $past(auth_rem)));
    // R5
    auth_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !load && (auth_rem != '0) |=> pay_rem == $past(pay_rem));
endmodule

// File: rtl/job_blk_stub.sv
module job_blk_stub (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic out_read,
    output logic in_full,
    output logic out_full
);
    logic move;
    assign move = in_full && !out_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_full  <= 1'b0;
            out_full <= 1'b0;
        end else begin
            if (accept)    in_full <= 1'b1;
            else if (move) in_full <= 1'b0;
            if (move)          out_full <= 1'b1;
            else if (out_read) out_full <= 1'b0;
        end
    end

    // R7
    fill_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> in_full);
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_full && !out_read |=> out_full);
endmodule

// File: rtl/job_len_seq.sv
module job_len_seq
    import job_len_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int HI_W      = 29,
    parameter int BLK_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [1:0]             rd_sel,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   combined_mode,
    input  logic                   save_ctx,
    input  logic                   ctx_read,
    input  logic                   blk_wr,
    output logic                   blk_accept,
    input  logic                   out_read,
    output logic                   job_start,
    output logic                   job_done,
    output logic [DATA_W+HI_W-1:0] pay_remain,
    output logic [DATA_W-1:0]      auth_remain,
    output logic                   in_ready,
    output logic                   out_ready,
    output logic                   ctx_ready,
    output logic                   save_ready
);
    localparam int PAY_W = DATA_W + HI_W;

    seq_state_t state_q, state_d;
    logic start_go, start_comb, cnt_empty, in_full, out_full;
    logic finish, start_q, done_q, save_q, endless_q;
    logic [PAY_W-1:0]  start_pay;
    logic [DATA_W-1:0] start_auth;

    job_len_regs #(.DATA_W(DATA_W), .HI_W(HI_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctx_open(state_q == ST_IDLE), .combined_mode(combined_mode),
        .start_go(start_go), .start_pay(start_pay), .start_auth(start_auth),
        .start_comb(start_comb)
    );

    job_len_counters #(.PAY_W(PAY_W), .AUTH_W(DATA_W), .BLK_BYTES(BLK_BYTES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(start_go), .load_pay(start_pay),
        .load_auth(start_auth), .dec(blk_accept), .pay_rem(pay_remain),
        .auth_rem(auth_remain), .cnt_empty(cnt_empty)
    );

    job_blk_stub u_stub (
        .clk(clk), .rst_n(rst_n), .accept(blk_accept), .out_read(out_read),
        .in_full(in_full), .out_full(out_full)
    );

    assign finish = (state_q == ST_RUN) && !endless_q && cnt_empty && !in_full && !out_full;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_go) state_d = ST_RUN;
            ST_RUN:  if (finish)   state_d = save_q ? ST_SAVE : ST_IDLE;
            ST_SAVE: if (ctx_read) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and job attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            done_q    <= 1'b0;
            save_q    <= 1'b0;
            endless_q <= 1'b0;
        end else begin
            start_q <= (state_q == ST_IDLE) && start_go;
            done_q  <= finish;
            if ((state_q == ST_IDLE) && start_go) begin
                save_q    <= save_ctx;
                endless_q <= !start_comb && (start_pay == '0);
            end
        end
    end

    always_comb begin
        job_start  = start_q;
        job_done   = done_q;
        ctx_ready  = (state_q == ST_IDLE);
        save_ready = (state_q == ST_SAVE);
        out_ready  = out_full;
        in_ready   = (state_q == ST_RUN) && !in_full && (endless_q || !cnt_empty);
        blk_accept = blk_wr && in_ready;
        rd_data    = '0;
        if (rd_sel == SEL_STATUS)
            rd_data[3:0] = {save_ready, ctx_ready, out_ready, in_ready};
    end

    // R9
    endless_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        endless_q |-> !job_done);
    // R10
    save_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_ready |-> save_q);
    // R4
    start_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> (endless_q || (pay_remain != '0) || (auth_remain != '0)));
    // R6
    accept_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_accept |-> !in_full);
    // R8
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |-> (pay_remain == '0) && (auth_remain == '0) && !out_ready);
endmodule

// File: tb/job_len_seq_bench.sv
module job_len_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic combined_mode = 1'b0, save_ctx = 1'b0, ctx_read = 1'b0;
    logic blk_wr = 1'b0, out_read = 1'b0;
    logic blk_accept, job_start, job_done, in_ready, out_ready, ctx_ready, save_ready;
    logic [60:0] pay_remain;
    logic [31:0] auth_remain;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    job_len_seq u_job_len_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .combined_mode(combined_mode),
        .save_ctx(save_ctx), .ctx_read(ctx_read), .blk_wr(blk_wr),
        .blk_accept(blk_accept), .out_read(out_read), .job_start(job_start),
        .job_done(job_done), .pay_remain(pay_remain), .auth_remain(auth_remain),
        .in_ready(in_ready), .out_ready(out_ready), .ctx_ready(ctx_ready),
        .save_ready(save_ready)
    );

    function automatic longint unsigned sub_blk(longint unsigned v);
        return (v < 16) ? 0 : v - 16;
    endfunction

    function automatic longint unsigned nblk(longint unsigned v);
        return (v + 15) / 16;
    endfunction

    task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; blk_wr = 1'b0; out_read = 1'b0; ctx_read = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic run_job(bit comb, longint unsigned plen, longint unsigned alen, bit sv);
        longint unsigned ep, ea;
        int blocks = 0;
        int guard = 0;
        bit acc;
        combined_mode = comb; save_ctx = sv;
        wr(2'd0, plen[31:0]);
        if (comb) begin
            wr(2'd1, {3'b0, plen[60:32]});
            chk(job_start == 1'b0, "R3 hi write stores only", job_start, 0);
            wr(2'd2, alen[31:0]);
        end else begin
            wr(2'd1, {3'b0, plen[60:32]});
        end
        ep = plen; ea = comb ? alen : 0;
        chk(job_start == 1'b1, comb ? "R3 launch" : "R2 launch", job_start, 1);
        chk(pay_remain == ep, "R2/R3 pay load", pay_remain, ep);
        chk(auth_remain == ea, "R2/R3 auth load", auth_remain, ea);
        save_ctx = 1'b0;
        while (!job_done && guard < 2000) begin
            acc = in_ready && ($urandom % 4 != 0);
            blk_wr = acc;
            out_read = ($urandom % 2 == 0);
            step();
            guard++;
            if (acc) begin
                blocks++;
                if (ea != 0) ea = sub_blk(ea); else ep = sub_blk(ep);
                chk(pay_remain == ep, "R5 pay count", pay_remain, ep);
                chk(auth_remain == ea, "R5 auth count", auth_remain, ea);
            end
        end
        blk_wr = 1'b0; out_read = 1'b0;
        chk(job_done == 1'b1, "R8 done reached", job_done, 1);
        chk(blocks == int'(nblk(plen) + (comb ? nblk(alen) : 0)), "R5 block total",
            blocks, nblk(plen) + (comb ? nblk(alen) : 0));
        chk(ctx_ready == !sv, "R8/R10 ctx_ready at done", ctx_ready, !sv);
        chk(save_ready == sv, "R10 save_ready at done", save_ready, sv);
        step();
        chk(job_done == 1'b0, "R8 done one cycle", job_done, 0);
        if (sv) begin
            chk(!(ctx_ready && save_ready), "R10 exclusive", {ctx_ready, save_ready}, 2'b01);
            ctx_read = 1'b1;
            step();
            ctx_read = 1'b0;
            chk(ctx_ready && !save_ready, "R10 collect", {ctx_ready, save_ready}, 2'b10);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #1;
        do_reset();
        // R1 reset state
        chk(ctx_ready && !in_ready && !out_ready && !save_ready, "R1 flags",
            {ctx_ready, in_ready, out_ready, save_ready}, 4'b1000);
        chk(!job_start && !job_done && pay_remain == 0 && auth_remain == 0, "R1 counts",
            pay_remain, 0);
        // R11 status word in idle
        rd_sel = 2'd3; #1;
        chk(rd_data == 32'h4, "R11 status idle", rd_data, 32'h4);

        // R6: block write while idle has no effect
        blk_wr = 1'b1; step(); blk_wr = 1'b0;
        chk(!out_ready && !in_ready, "R6 idle blk_wr ignored", out_ready, 0);

        // R2: basic mode, auth write does not launch; large 61-bit value loads
        combined_mode = 1'b0;
        wr(2'd2, 32'h40);
        chk(job_start == 1'b0 && ctx_ready, "R2 auth write no launch", job_start, 0);
        wr(2'd0, 32'hDEADBEEF);
        wr(2'd1, 32'hFABCDEF0);
        chk(job_start == 1'b1, "R2 hi launch", job_start, 1);
        chk(pay_remain == {29'h1ABCDEF0, 32'hDEADBEEF}, "R2 61-bit load", pay_remain,
            {29'h1ABCDEF0, 32'hDEADBEEF});
        chk(auth_remain == 0, "R2 auth zero", auth_remain, 0);
        for (int s = 0; s < 3; s++) begin
            rd_sel = 2'(s); #1;
            chk(rd_data == 0, "R11 length reads zero", rd_data, 0);
        end
        rd_sel = 2'd3; #1;
        chk(rd_data == 32'h1, "R11 status running", rd_data, 32'h1);
        // R12: writes while running ignored
        wr(2'd0, 32'h5);
        wr(2'd1, 32'h0);
        chk(job_start == 1'b0, "R12 no relaunch", job_start, 0);
        chk(pay_remain == {29'h1ABCDEF0, 32'hDEADBEEF}, "R12 counts held", pay_remain,
            {29'h1ABCDEF0, 32'hDEADBEEF});
        do_reset();

        // R6/R7: buffer timing with blk_wr held, no output reads
        combined_mode = 1'b0;
        wr(2'd0, 32'd100);
        wr(2'd1, 32'd0);
        blk_wr = 1'b1;
        step();
        chk(pay_remain == 84 && !in_ready && !out_ready, "R7 accept fills input",
            pay_remain, 84);
        step();
        chk(out_ready && in_ready && pay_remain == 84, "R7 move to output",
            {out_ready, in_ready}, 2'b11);
        step();
        step();
        chk(pay_remain == 68 && !in_ready && out_ready, "R6 full buffers block accept",
            pay_remain, 68);
        blk_wr = 1'b0;
        do_reset();

        // R4: combined mode, both lengths zero
        combined_mode = 1'b1;
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd0);
        chk(job_start == 1'b0 && ctx_ready, "R4 empty launch ignored", job_start, 0);
        step();
        chk(!in_ready && ctx_ready, "R4 still idle", in_ready, 0);

        // R3/R5: combined, auth first then payload, partial blocks
        run_job(1'b1, 5, 20, 1'b0);
        run_job(1'b1, 0, 33, 1'b1);
        run_job(1'b1, 48, 0, 1'b0);
        run_job(1'b0, 17, 0, 1'b1);

        // R9: endless basic job
        combined_mode = 1'b0;
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd0);
        chk(job_start == 1'b1, "R9 endless launch", job_start, 1);
        begin
            int acc_n = 0;
            bit seen_done = 0;
            for (int c = 0; c < 60; c++) begin
                if (in_ready) acc_n++;
                blk_wr = in_ready;
                out_read = 1'b1;
                step();
                if (job_done) seen_done = 1;
            end
            blk_wr = 1'b0; out_read = 1'b0;
            chk(!seen_done, "R9 never done", seen_done, 0);
            chk(acc_n >= 10, "R9 keeps accepting", acc_n, 10);
            chk(pay_remain == 0, "R9 count stays zero", pay_remain, 0);
        end
        do_reset();

        // random jobs
        for (int j = 0; j < 12; j++) begin
            bit comb;
            longint unsigned p, a;
            comb = ($urandom % 2 == 1);
            p = 64'($urandom % 130);
            a = comb ? 64'($urandom % 130) : 0;
            if (!comb && p == 0) p = 1;
            if (comb && p == 0 && a == 0) a = 16;
            run_job(comb, p, a, ($urandom % 2 == 1));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule